// File: doc/BRIEF.md
# PCM Transmit Serial Port

This block places one companded sample word per frame onto a time-division PCM highway. It runs on a fast system clock and watches the slower codec clocks as ordinary inputs. It passes them through synchronizers and acts on their rising edges. The frame sync input marks where the transmit timeslot starts.

Two timing modes are supported. In fixed-rate mode the master clock also serves as the bit clock. The word goes out on the first rising edges of that clock after frame sync rises. The width of the sync pulse, counted in master clocks, tells an ordinary frame from a signaling frame. In a signaling frame the last bit of the word is replaced by the signaling input, unless A-law coding is selected.

In variable-rate mode a separate data clock shifts the word out while frame sync is high. The word is sent again in each further timeslot for as long as sync stays high. No signaling substitution is done in this mode. The serial output is a data bit plus an output enable. A timeslot strobe, which gates an external highway buffer, is high only while bits are being driven.

Top module: `pcm_tx_port`

## Requirements
- R1: After reset, ser_oe, ts_strobe and ser_data are all 0.
- R2: In fixed-rate mode (var_mode=0), the word is driven on the first WORD_W rising edges of mclk after fsync rises, most significant bit first. ser_oe is 1 for exactly those WORD_W bit periods and falls on the next mclk rising edge.
- R3: A single-wide sync pulse (fsync high at one mclk rising edge only) gives an ordinary frame. The last bit sent is bit 0 of the word, whatever sig_in is.
- R4: A double-wide sync pulse (fsync high at two consecutive mclk rising edges) with alaw_sel=0 gives a signaling frame. The last bit sent is the level of sig_in.
- R5: When alaw_sel=1, a double-wide sync pulse causes no substitution, and the last bit sent is bit 0 of the word.
- R6: In variable-rate mode (var_mode=1), bits are driven on the rising edges of dclk that find fsync high, most significant bit first. No signaling substitution takes place, however long the sync pulse is.
- R7: In variable-rate mode, the same word is sent again in each further WORD_W-bit timeslot while fsync stays high at each dclk rising edge.
- R8: In variable-rate mode, a dclk rising edge that finds fsync low ends the output at once, even in the middle of a slot. ser_oe drops and ser_data returns to 0.
- R9: The word sent is sample_in as captured at the start of the frame. A change of sample_in during shifting does not alter the word in flight, and the next frame takes the new value.
- R10: ts_strobe always equals ser_oe, and ser_data is 0 whenever ser_oe is 0 (this stands for high impedance).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mclk | input | 1 | Master clock; this is the bit clock in fixed-rate mode |
| dclk | input | 1 | Data clock for variable-rate mode |
| fsync | input | 1 | Transmit frame sync / timeslot enable |
| var_mode | input | 1 | 0 = fixed-rate timing, 1 = variable-rate timing |
| alaw_sel | input | 1 | 1 = A-law coding, which disables signaling |
| sig_in | input | 1 | Signaling bit placed in the last bit position of signaling frames |
| sample_in | input | WORD_W | Parallel companded sample word |
| ser_data | output | 1 | Serial data bit |
| ser_oe | output | 1 | Serial data output enable |
| ts_strobe | output | 1 | Timeslot strobe for an external highway buffer |

## Verification
The bench aims at the last bit of the word. It sets sig_in opposite to bit 0, so that a design that substitutes on single-wide pulses, in A-law mode or in variable-rate mode sends the wrong final bit, and a design that never substitutes fails the double-wide case. The sample word is changed right after the first bit goes out, which exposes a design that shifts the live input instead of a captured copy. In variable-rate mode, sync is held for two full slots and is also dropped three bits into a slot. A design that sends the word only once, or keeps driving after sync falls, then shows the wrong enable.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

   // Progress of sync-width measurement within a fixed-rate frame
   typedef enum logic [1:0] {
      WS_IDLE  = 2'd0,
      WS_FIRST = 2'd1,
      WS_DONE  = 2'd2
   } width_state_e;

   // Signaling is only honoured in fixed-rate, non-A-law operation
   function automatic logic sig_permitted(input logic var_mode, input logic alaw);
      return !var_mode && !alaw;
   endfunction

endpackage

// File: rtl/pcm_sync_bus.sv
module pcm_sync_bus #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);

   initial begin
      assert (STAGES >= 2) else $error("pcm_sync_bus: STAGES must be at least 2");
      assert (WIDTH >= 1) else $error("pcm_sync_bus: WIDTH must be positive");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= '0;
            else        chain[g] <= d_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= '0;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   assign d_out = chain[STAGES-1];

endmodule

// File: rtl/pcm_bit_clock.sv
module pcm_bit_clock (
   input  logic clk,
   input  logic rst_n,
   input  logic mclk_s,
   input  logic dclk_s,
   input  logic var_mode,
   output logic bit_ev
);

   logic mclk_q;
   logic dclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mclk_q <= 1'b0;
         dclk_q <= 1'b0;
      end else begin
         mclk_q <= mclk_s;
         dclk_q <= dclk_s;
      end
   end

   logic m_rise;
   logic d_rise;
   assign m_rise = mclk_s & ~mclk_q;
   assign d_rise = dclk_s & ~dclk_q;
   assign bit_ev = var_mode ? d_rise : m_rise;

   // R2
   ev_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_ev && $stable(var_mode)) |=> !bit_ev);

endmodule

// File: rtl/pcm_frame_tracker.sv
module pcm_frame_tracker
   import pcm_tx_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic bit_ev,
   input  logic fs_lvl,
   output logic frame_start,
   output logic sig_frame
);

   logic         fs_prev_q;
   width_state_e ws_q;
   logic         sig_q;

   assign frame_start = bit_ev & fs_lvl & ~fs_prev_q;
   assign sig_frame   = sig_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fs_prev_q <= 1'b0;
         ws_q      <= WS_IDLE;
         sig_q     <= 1'b0;
      end else if (bit_ev) begin
         fs_prev_q <= fs_lvl;
         if (frame_start) begin
            ws_q  <= WS_FIRST;
            sig_q <= 1'b0;
         end else if (ws_q == WS_FIRST) begin
            ws_q  <= WS_DONE;
            sig_q <= fs_lvl;
         end
      end
   end

   // R4
   sig_needs_wide_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sig_q) |-> ($past(fs_lvl) && $past(bit_ev)));

   // R3
   start_clears_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !sig_q);

endmodule

// File: rtl/pcm_word_shifter.sv
module pcm_word_shifter #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_ev,
   input  logic              fs_lvl,
   input  logic              frame_start,
   input  logic              var_mode,
   input  logic              sig_use,
   input  logic              sig_bit,
   input  logic [WORD_W-1:0] sample_in,
   output logic              ser_data,
   output logic              ser_oe,
   output logic              ts_strobe
);

   localparam int CW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
   localparam logic [CW-1:0] LAST_IDX = CW'(WORD_W - 1);

   initial begin
      assert (WORD_W >= 3) else $error("pcm_word_shifter: WORD_W must be at least 3");
   end

   function automatic logic pick(input logic [WORD_W-1:0] w, input int idx);
      if (idx >= 0 && idx < WORD_W) return w[WORD_W-1-idx];
      return 1'b0;
   endfunction

   logic              act_q;
   logic [CW-1:0]     cnt_q;
   logic [WORD_W-1:0] word_q;
   logic              dat_q;
   logic              oe_q;
   logic              stb_q;

   logic          last;
   logic [CW-1:0] inc;
   logic          nxt_bit;
   logic          begin_slot;

   always_comb begin
      last    = (cnt_q == LAST_IDX);
      inc     = cnt_q + CW'(1);
      nxt_bit = pick(word_q, int'(inc));
      if (!var_mode && sig_use && inc == LAST_IDX) nxt_bit = sig_bit;
      begin_slot = var_mode ? (fs_lvl && !act_q) : (frame_start && !act_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         cnt_q  <= '0;
         word_q <= '0;
         dat_q  <= 1'b0;
         oe_q   <= 1'b0;
         stb_q  <= 1'b0;
      end else if (bit_ev) begin
         if (begin_slot) begin
            act_q  <= 1'b1;
            cnt_q  <= '0;
            word_q <= sample_in;
            dat_q  <= sample_in[WORD_W-1];
            oe_q   <= 1'b1;
            stb_q  <= 1'b1;
         end else if (act_q && var_mode && !fs_lvl) begin
            act_q <= 1'b0;
            dat_q <= 1'b0;
            oe_q  <= 1'b0;
            stb_q <= 1'b0;
         end else if (act_q && last && var_mode) begin
            cnt_q <= '0;
            dat_q <= word_q[WORD_W-1];
         end else if (act_q && last) begin
            act_q <= 1'b0;
            dat_q <= 1'b0;
            oe_q  <= 1'b0;
            stb_q <= 1'b0;
         end else if (act_q) begin
            cnt_q <= inc;
            dat_q <= nxt_bit;
         end
      end
   end

   assign ser_data  = dat_q;
   assign ser_oe    = oe_q;
   assign ts_strobe = stb_q;

   // R2
   oe_rise_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe_q) |-> $past(bit_ev));

   // R8
   oe_fall_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(oe_q) |-> $past(bit_ev));

   // R2
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bit_ev) |-> $stable(dat_q));

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_q |-> (!dat_q && !stb_q));

   // R9
   word_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(act_q) && act_q && !$past(begin_slot)) |-> $stable(word_q));

endmodule

// File: rtl/pcm_tx_port.sv
module pcm_tx_port
   import pcm_tx_pkg::*;
#(
   parameter int WORD_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mclk,
   input  logic              dclk,
   input  logic              fsync,
   input  logic              var_mode,
   input  logic              alaw_sel,
   input  logic              sig_in,
   input  logic [WORD_W-1:0] sample_in,
   output logic              ser_data,
   output logic              ser_oe,
   output logic              ts_strobe
);

   localparam int NSYNC = 4;

   logic [NSYNC-1:0] raw_bus;
   logic [NSYNC-1:0] sync_bus;

   assign raw_bus = {sig_in, fsync, dclk, mclk};

   pcm_sync_bus #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (raw_bus),
      .d_out (sync_bus)
   );

   logic mclk_s, dclk_s, fs_s, sig_s;
   assign mclk_s = sync_bus[0];
   assign dclk_s = sync_bus[1];
   assign fs_s   = sync_bus[2];
   assign sig_s  = sync_bus[3];

   logic bit_ev;

   pcm_bit_clock u_bclk (
      .clk      (clk),
      .rst_n    (rst_n),
      .mclk_s   (mclk_s),
      .dclk_s   (dclk_s),
      .var_mode (var_mode),
      .bit_ev   (bit_ev)
   );

   logic frame_start;
   logic sig_frame;

   pcm_frame_tracker u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_ev      (bit_ev),
      .fs_lvl      (fs_s),
      .frame_start (frame_start),
      .sig_frame   (sig_frame)
   );

   logic sig_use;
   assign sig_use = sig_frame && sig_permitted(var_mode, alaw_sel);

   pcm_word_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_ev      (bit_ev),
      .fs_lvl      (fs_s),
      .frame_start (frame_start),
      .var_mode    (var_mode),
      .sig_use     (sig_use),
      .sig_bit     (sig_s),
      .sample_in   (sample_in),
      .ser_data    (ser_data),
      .ser_oe      (ser_oe),
      .ts_strobe   (ts_strobe)
   );

   // R10
   strobe_tracks_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ser_oe == ts_strobe);

   // R5
   alaw_no_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alaw_sel || var_mode) |-> !sig_use);

endmodule

// File: tb/pcm_tx_port_test.sv
module pcm_tx_port_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mclk = 1'b0;
   logic       dclk = 1'b0;
   logic       fsync = 1'b0;
   logic       var_mode = 1'b0;
   logic       alaw_sel = 1'b0;
   logic       sig_in = 1'b0;
   logic [7:0] sample_in = 8'h00;
   logic       ser_data, ser_oe, ts_strobe;

   always #5 clk = ~clk;

   pcm_tx_port uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .mclk      (mclk),
      .dclk      (dclk),
      .fsync     (fsync),
      .var_mode  (var_mode),
      .alaw_sel  (alaw_sel),
      .sig_in    (sig_in),
      .sample_in (sample_in),
      .ser_data  (ser_data),
      .ser_oe    (ser_oe),
      .ts_strobe (ts_strobe)
   );

   int    checks = 0;
   int    errors = 0;
   bit    done = 0;
   event  smp_ev;
   logic [1:0] q_exp [$];
   string      q_tag [$];

   // Monitor: pops one expected item per bit period
   initial begin
      forever begin
         logic [1:0] e;
         string      t;
         @(smp_ev);
         e = q_exp.pop_front();
         t = q_tag.pop_front();
         checks++;
         if (ser_oe !== e[1] || ser_data !== e[0]) begin
            errors++;
            $display("FAIL %s: oe,data = %b,%b expected %b,%b", t, ser_oe, ser_data, e[1], e[0]);
         end
         checks++;
         if (ts_strobe !== ser_oe || (!ser_oe && ser_data !== 1'b0)) begin
            errors++;
            $display("FAIL R10: strobe,oe,data = %b,%b,%b expected strobe==oe and data 0 when idle",
                     ts_strobe, ser_oe, ser_data);
         end
      end
   end

   // One codec clock rising edge with a given sync level, then sample
   task automatic bit_rise(input logic fs_v, input logic e_oe, input logic e_d, input string tag);
      @(negedge clk);
      if (var_mode) dclk = 1'b0; else mclk = 1'b0;
      fsync = fs_v;
      repeat (8) @(negedge clk);
      if (var_mode) dclk = 1'b1; else mclk = 1'b1;
      repeat (8) @(negedge clk);
      q_exp.push_back({e_oe, e_d});
      q_tag.push_back(tag);
      -> smp_ev;
   endtask

   // Fixed-rate frame: expected last bit from the signaling rules
   task automatic fixed_frame(input logic [7:0] w, input logic dbl, input bit change,
                              input logic [7:0] late, input string tag);
      logic lsb;
      lsb = (dbl && !alaw_sel) ? sig_in : w[0];
      sample_in = w;
      bit_rise(1'b1, 1'b1, w[7], "R2");
      if (change) sample_in = late;
      bit_rise(dbl, 1'b1, w[6], change ? "R9" : "R2");
      for (int i = 2; i < 7; i++) bit_rise(1'b0, 1'b1, w[7-i], change ? "R9" : "R2");
      bit_rise(1'b0, 1'b1, lsb, tag);
      bit_rise(1'b0, 1'b0, 1'b0, "R2");
      bit_rise(1'b0, 1'b0, 1'b0, "R10");
   endtask

   // Variable-rate frame: sync high for n data clock edges
   task automatic var_frame(input logic [7:0] w, input int n, input string tag);
      sample_in = w;
      for (int i = 0; i < n; i++) bit_rise(1'b1, 1'b1, w[7 - (i % 8)], (i >= 8) ? "R7" : tag);
      bit_rise(1'b0, 1'b0, 1'b0, "R8");
      bit_rise(1'b0, 1'b0, 1'b0, "R10");
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      checks++;
      if (ser_oe !== 1'b0 || ts_strobe !== 1'b0 || ser_data !== 1'b0) begin
         errors++;
         $display("FAIL R1: oe,strobe,data = %b,%b,%b expected 0,0,0", ser_oe, ts_strobe, ser_data);
      end
      bit_rise(1'b0, 1'b0, 1'b0, "R1");

      // Fixed rate, mu-law
      sig_in = 1'b0;
      fixed_frame(8'hA5, 1'b0, 0, 8'h00, "R3");
      sig_in = 1'b1;
      fixed_frame(8'h3C, 1'b0, 0, 8'h00, "R3");
      fixed_frame(8'h3C, 1'b1, 0, 8'h00, "R4");
      sig_in = 1'b0;
      fixed_frame(8'h81, 1'b1, 0, 8'h00, "R4");
      // A-law blocks signaling
      alaw_sel = 1'b1;
      sig_in = 1'b1;
      fixed_frame(8'h3C, 1'b1, 0, 8'h00, "R5");
      alaw_sel = 1'b0;
      // Capture at frame start
      sig_in = 1'b0;
      fixed_frame(8'h96, 1'b0, 1, 8'h69, "R9");
      fixed_frame(8'h69, 1'b0, 0, 8'h00, "R9");

      // Variable rate
      @(negedge clk);
      var_mode = 1'b1;
      repeat (4) @(negedge clk);
      sig_in = 1'b0;
      var_frame(8'hC3, 8, "R6");
      var_frame(8'h4B, 16, "R7");
      var_frame(8'h5A, 3, "R8");
      var_frame(8'hE7, 8, "R9");

      repeat (4) @(negedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule